// File: doc/BRIEF.md
# Zoned Associative Page Translation Lookup

This block translates a virtual address into a physical address by searching a fully associative table of 64 page entries. Each entry describes a page of its own size (1 KB up to 16 MB in steps of four). It also carries an 8-bit owner tag, write and execute permission bits, and a 4-bit zone selector. The zone selector picks a 2-bit code out of a 32-bit zone protection word. That code can hide the entry from user-mode accesses, leave the entry's own permissions in force, or grant write and execute outright.

A lookup presents the virtual address, the access kind (read, write or fetch), the privilege level, the current process ID and the zone protection word. All of these are captured on a rising clock edge. Hit, fault, entry index, physical address and page-size code are then produced combinationally from the captured values and the stored entries. Entries are loaded through a single write port, one entry per cycle; how entries are chosen for refill is left to the surrounding logic.

Top module: `zone_tlb_lookup`

## Requirements
- R1: When `we_i` is high at a rising edge, the entry at `wr_idx_i` takes all written fields, and a lookup captured at that same edge already sees the new contents. Reset clears the valid flag of every entry.
- R2: An entry whose valid flag is low never takes part in a lookup, whatever its other fields hold.
- R3: Size code c (0..7) gives a page of 1 KB × 4^c. The lookup compares virtual address bits [31:10+2c] with the same bits of the entry's page number (page base = page number shifted left by 10). The bits below the page size are ignored.
- R4: An owner tag of 0 matches every process ID. Any other owner tag matches only a process ID equal to it.
- R5: The zone code of an entry with zone selector z is bits [31-2z:30-2z] of the zone protection word. When z is above `ZONE_MAX`, or when `ZONES_EN` is 0, the code is 1.
- R6: Zone code 0 makes the entry a non-match for user accesses (`user_i`=1), so the search goes on to later entries. Supervisor accesses use the entry's own bits. Code 1 always uses the entry's own bits.
- R7: Zone code 2 grants write and execute to supervisor accesses only; user accesses keep the entry's own bits. Zone code 3 grants write and execute to both privilege levels.
- R8: Access kind encoding is 0 read, 1 write, 2 fetch, and 3 behaves as a read. The winning entry raises `fault_o` (and leaves `hit_o` low) on a write without write permission or a fetch without execute permission. A read never faults, and `hit_o` and `fault_o` are never high together.
- R9: Among qualifying entries (valid, address match, owner match, not hidden by zone), the lowest index wins. If it faults, later entries are not considered.
- R10: On a hit, `idx_o` is the winning index, `size_o` its size code, and `paddr_o` the entry's real page base above the page size combined with the virtual address below it. Without a hit, all three are zero.
- R11: Lookup inputs act only through the values captured at a rising edge. Changes between edges do not move the outputs.
- R12: During and right after reset, with no entry loaded, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 6 | Entry index to write |
| wr_epn_i | input | 22 | Virtual page number (address bits 31:10) |
| wr_size_i | input | 3 | Page size code |
| wr_valid_i | input | 1 | Entry valid flag |
| wr_rpn_i | input | 22 | Real page number (address bits 31:10) |
| wr_ex_i | input | 1 | Execute permission |
| wr_wr_i | input | 1 | Write permission |
| wr_zone_i | input | 4 | Zone selector |
| wr_tid_i | input | 8 | Owner process tag, 0 = any |
| va_i | input | 32 | Virtual address to translate |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| user_i | input | 1 | 1 = user mode, 0 = supervisor |
| pid_i | input | 8 | Current process ID |
| zpr_i | input | 32 | Zone protection word, 2 bits per zone |
| hit_o | output | 1 | Translation succeeded |
| fault_o | output | 1 | Winning entry denies this access |
| idx_o | output | 6 | Winning entry index on hit |
| paddr_o | output | 32 | Translated physical address on hit |
| size_o | output | 3 | Size code of the winning entry on hit |

## Verification
An entry write and a lookup can fall on the same rising edge. The bench provokes this by loading an entry and presenting an address inside that entry's page in the same cycle, and it expects a hit on the freshly written contents. During the random phase about a third of all lookups share their edge with a write to a random index, often the very entry under lookup. The expected outputs come from a bench model that applies the write first and then searches the updated table. A second kind of overlap is two qualifying entries for the same address with different permissions or zone treatment; the bench judges it by the lowest-index rule, including the case where the lower entry faults.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

  localparam int VA_W      = 32;
  localparam int PN_W      = 22;
  localparam int PG_OFF    = VA_W - PN_W;  // smallest page: 1 KB
  localparam int SZ_W      = 3;
  localparam int ZSEL_W    = 4;
  localparam int TID_W     = 8;
  localparam int ZPR_W     = 32;

  typedef enum logic [1:0] {
    ACC_RD   = 2'd0,
    ACC_WR   = 2'd1,
    ACC_FE   = 2'd2,
    ACC_RSVD = 2'd3
  } acc_e;

  typedef struct packed {
    logic [PN_W-1:0]   epn;
    logic [SZ_W-1:0]   size;
    logic              valid;
    logic [PN_W-1:0]   rpn;
    logic              ex;
    logic              wr;
    logic [ZSEL_W-1:0] zone;
    logic [TID_W-1:0]  tid;
  } tlb_ent_t;

  // ones above the page offset for a size code (1 KB * 4^code)
  function automatic logic [VA_W-1:0] page_mask(input logic [SZ_W-1:0] code);
    logic [VA_W-1:0] ones;
    logic [4:0]      sh;
    ones = '1;
    sh   = 5'(PG_OFF) + {1'b0, code, 1'b0};
    return ones << sh;
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
`timescale 1ns/1ps
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter  int N_ENT = 64,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  tlb_ent_t         wr_ent_i,
  output tlb_ent_t         ents_o [N_ENT]
);

  tlb_ent_t ent_q [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[e] <= '0;
      end else if (we_i && (wr_idx_i == IDX_W'(e))) begin
        ent_q[e] <= wr_ent_i;
      end
    end
  end

  assign ents_o = ent_q;

  // R1: written entry holds the written fields on the next cycle
  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ent_q[$past(wr_idx_i)] == $past(wr_ent_i)));

endmodule

// File: rtl/tlb_match_array.sv
`timescale 1ns/1ps
module tlb_match_array
  import tlb_pkg::*;
#(
  parameter  int          N_ENT    = 64,
  parameter  bit          ZONES_EN = 1'b1,
  parameter  int unsigned ZONE_MAX = 11
) (
  input  tlb_ent_t         ents_i [N_ENT],
  input  logic [VA_W-1:0]  va_i,
  input  acc_e             acc_i,
  input  logic             user_i,
  input  logic [TID_W-1:0] pid_i,
  input  logic [ZPR_W-1:0] zpr_i,
  output logic [N_ENT-1:0] qual_o,
  output logic [N_ENT-1:0] deny_o,
  output logic [VA_W-1:0]  pa_o [N_ENT]
);

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    tlb_ent_t        ent;
    logic [VA_W-1:0] mask;
    logic [VA_W-1:0] base_v;
    logic [VA_W-1:0] base_p;
    logic [5:0]      zsh;
    logic [1:0]      zraw;
    logic [1:0]      zc;
    logic            addr_ok;
    logic            tid_ok;
    logic            hidden;
    logic            can_wr;
    logic            can_ex;

    assign ent    = ents_i[e];
    assign mask   = page_mask(ent.size);
    assign base_v = {ent.epn, {PG_OFF{1'b0}}};
    assign base_p = {ent.rpn, {PG_OFF{1'b0}}};

    always_comb begin
      zsh  = 6'd30 - {1'b0, ent.zone, 1'b0};
      zraw = 2'((zpr_i >> zsh) & 32'd3);
      if (!ZONES_EN || (32'(ent.zone) > ZONE_MAX)) zc = 2'd1;
      else                                         zc = zraw;
    end

    assign addr_ok = ((va_i ^ base_v) & mask) == '0;
    assign tid_ok  = (ent.tid == '0) || (ent.tid == pid_i);
    assign hidden  = (zc == 2'd0) && user_i;

    // zone overrides of the entry's own permission bits
    assign can_wr = ent.wr | (zc == 2'd3) | ((zc == 2'd2) & ~user_i);
    assign can_ex = ent.ex | (zc == 2'd3) | ((zc == 2'd2) & ~user_i);

    assign qual_o[e] = ent.valid & addr_ok & tid_ok & ~hidden;
    assign deny_o[e] = ((acc_i == ACC_WR) & ~can_wr) | ((acc_i == ACC_FE) & ~can_ex);
    assign pa_o[e]   = (base_p & mask) | (va_i & ~mask);
  end

endmodule

// File: rtl/tlb_first_pick.sv
`timescale 1ns/1ps
module tlb_first_pick #(
  parameter  int N_ENT = 64,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] qual_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    found_o = |qual_i;
    idx_o   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (qual_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/zone_tlb_lookup.sv
`timescale 1ns/1ps
module zone_tlb_lookup
  import tlb_pkg::*;
#(
  parameter  int          N_ENT    = 64,
  parameter  bit          ZONES_EN = 1'b1,
  parameter  int unsigned ZONE_MAX = 11,
  localparam int          IDX_W    = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [PN_W-1:0]   wr_epn_i,
  input  logic [SZ_W-1:0]   wr_size_i,
  input  logic              wr_valid_i,
  input  logic [PN_W-1:0]   wr_rpn_i,
  input  logic              wr_ex_i,
  input  logic              wr_wr_i,
  input  logic [ZSEL_W-1:0] wr_zone_i,
  input  logic [TID_W-1:0]  wr_tid_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [1:0]        acc_i,
  input  logic              user_i,
  input  logic [TID_W-1:0]  pid_i,
  input  logic [ZPR_W-1:0]  zpr_i,
  output logic              hit_o,
  output logic              fault_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [VA_W-1:0]   paddr_o,
  output logic [SZ_W-1:0]   size_o
);

  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q;
  logic [TID_W-1:0] pid_q;
  logic [ZPR_W-1:0] zpr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q   <= '0;
      acc_q  <= '0;
      user_q <= 1'b0;
      pid_q  <= '0;
      zpr_q  <= '0;
    end else begin
      va_q   <= va_i;
      acc_q  <= acc_i;
      user_q <= user_i;
      pid_q  <= pid_i;
      zpr_q  <= zpr_i;
    end
  end

  tlb_ent_t wr_ent;
  tlb_ent_t ents [N_ENT];

  always_comb begin
    wr_ent.epn   = wr_epn_i;
    wr_ent.size  = wr_size_i;
    wr_ent.valid = wr_valid_i;
    wr_ent.rpn   = wr_rpn_i;
    wr_ent.ex    = wr_ex_i;
    wr_ent.wr    = wr_wr_i;
    wr_ent.zone  = wr_zone_i;
    wr_ent.tid   = wr_tid_i;
  end

  tlb_entry_store #(.N_ENT(N_ENT)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .wr_idx_i (wr_idx_i),
    .wr_ent_i (wr_ent),
    .ents_o   (ents)
  );

  logic [N_ENT-1:0] qual;
  logic [N_ENT-1:0] deny;
  logic [VA_W-1:0]  pa_vec [N_ENT];

  tlb_match_array #(
    .N_ENT    (N_ENT),
    .ZONES_EN (ZONES_EN),
    .ZONE_MAX (ZONE_MAX)
  ) u_match (
    .ents_i (ents),
    .va_i   (va_q),
    .acc_i  (acc_e'(acc_q)),
    .user_i (user_q),
    .pid_i  (pid_q),
    .zpr_i  (zpr_q),
    .qual_o (qual),
    .deny_o (deny),
    .pa_o   (pa_vec)
  );

  logic             found;
  logic [IDX_W-1:0] sel_idx;

  tlb_first_pick #(.N_ENT(N_ENT)) u_pick (
    .qual_i  (qual),
    .found_o (found),
    .idx_o   (sel_idx)
  );

  logic sel_deny;
  assign sel_deny = deny[sel_idx];

  assign hit_o   = found & ~sel_deny;
  assign fault_o = found & sel_deny;
  assign idx_o   = hit_o ? sel_idx : '0;
  assign paddr_o = hit_o ? pa_vec[sel_idx] : '0;
  assign size_o  = hit_o ? ents[sel_idx].size : '0;

  logic [N_ENT-1:0] below_sel;
  assign below_sel = (N_ENT'(1) << sel_idx) - N_ENT'(1);

  // R8: hit and fault exclusive
  a_r8_hit_xor_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && fault_o));

  // R8: reads never fault
  a_r8_read_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc_q == 2'd0) || (acc_q == 2'd3)) |-> !fault_o);

  // R2: a hit always lands on a valid entry
  a_r2_hit_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ents[idx_o].valid);

  // R9: no qualifying entry below the winner
  a_r9_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o || fault_o) |-> ((qual & below_sel) == '0));

  // R10: page offset of smallest page passes through
  a_r10_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (paddr_o[PG_OFF-1:0] == va_q[PG_OFF-1:0]));

  // R10: quiet outputs without a hit
  a_r10_quiet_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> ((idx_o == '0) && (paddr_o == '0) && (size_o == '0)));

endmodule

// File: tb/zone_tlb_lookup_tb_top.sv
`timescale 1ns/1ps
module zone_tlb_lookup_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NE         = 64;
  localparam int ZMAX       = 11;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        we;
  logic [5:0]  wr_idx;
  logic [21:0] wr_epn;
  logic [2:0]  wr_size;
  logic        wr_valid;
  logic [21:0] wr_rpn;
  logic        wr_ex;
  logic        wr_wr;
  logic [3:0]  wr_zone;
  logic [7:0]  wr_tid;
  logic [31:0] va;
  logic [1:0]  acc;
  logic        user;
  logic [7:0]  pid;
  logic [31:0] zpr;
  logic        hit_o;
  logic        fault_o;
  logic [5:0]  idx_o;
  logic [31:0] paddr_o;
  logic [2:0]  size_o;

  int n_chk = 0;
  int n_bad = 0;

  bit [21:0] m_epn  [NE];
  bit [2:0]  m_size [NE];
  bit        m_val  [NE];
  bit [21:0] m_rpn  [NE];
  bit        m_ex   [NE];
  bit        m_wr   [NE];
  bit [3:0]  m_zone [NE];
  bit [7:0]  m_tid  [NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  zone_tlb_lookup dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .wr_idx_i(wr_idx),
    .wr_epn_i(wr_epn), .wr_size_i(wr_size), .wr_valid_i(wr_valid),
    .wr_rpn_i(wr_rpn), .wr_ex_i(wr_ex), .wr_wr_i(wr_wr),
    .wr_zone_i(wr_zone), .wr_tid_i(wr_tid), .va_i(va), .acc_i(acc),
    .user_i(user), .pid_i(pid), .zpr_i(zpr), .hit_o(hit_o),
    .fault_o(fault_o), .idx_o(idx_o), .paddr_o(paddr_o), .size_o(size_o)
  );

  function automatic bit [31:0] zfield(input int z, input int code);
    return 32'(code) << (30 - 2*z);
  endfunction

  // expected result from the requirement text
  function automatic void model(output bit e_hit, output bit e_fault,
                                output bit [5:0] e_idx, output bit [31:0] e_pa,
                                output bit [2:0] e_sz);
    e_hit = 0; e_fault = 0; e_idx = 0; e_pa = 0; e_sz = 0;
    for (int i = 0; i < NE; i++) begin
      bit [31:0] mask;
      int zc;
      bit w, x;
      if (!m_val[i]) continue;
      mask = 32'hFFFF_FFFF << (10 + 2*int'(m_size[i]));
      if ((va & mask) != ({m_epn[i], 10'b0} & mask)) continue;
      if (m_tid[i] != 0 && m_tid[i] != pid) continue;
      if (int'(m_zone[i]) > ZMAX) zc = 1;
      else zc = int'((zpr >> (30 - 2*int'(m_zone[i]))) & 32'd3);
      if (zc == 0 && user) continue;
      w = m_wr[i]; x = m_ex[i];
      if (zc == 3 || (zc == 2 && !user)) begin w = 1; x = 1; end
      if ((acc == 2'd1 && !w) || (acc == 2'd2 && !x)) begin
        e_fault = 1;
        return;
      end
      e_hit = 1; e_idx = 6'(i); e_sz = m_size[i];
      e_pa  = ({m_rpn[i], 10'b0} & mask) | (va & ~mask);
      return;
    end
  endfunction

  task automatic check(input string tag);
    bit h, f; bit [5:0] ix; bit [31:0] pa; bit [2:0] sz;
    string t;
    model(h, f, ix, pa, sz);
    t = tag;
    if (t == "") t = f ? "R8" : (h ? "R10" : "R3");
    n_chk++;
    if (hit_o !== h || fault_o !== f || idx_o !== ix || paddr_o !== pa || size_o !== sz) begin
      n_bad++;
      $display("FAIL %s: got hit=%0d fault=%0d idx=%0d pa=%h sz=%0d exp hit=%0d fault=%0d idx=%0d pa=%h sz=%0d",
               t, hit_o, fault_o, idx_o, paddr_o, size_o, h, f, ix, pa, sz);
    end
  endtask

  task automatic set_write(input int i, input bit [21:0] epn, input bit [2:0] sz,
                           input bit v, input bit [21:0] rpn, input bit x,
                           input bit w, input bit [3:0] z, input bit [7:0] t);
    we = 1; wr_idx = 6'(i); wr_epn = epn; wr_size = sz; wr_valid = v;
    wr_rpn = rpn; wr_ex = x; wr_wr = w; wr_zone = z; wr_tid = t;
  endtask

  task automatic set_look(input bit [31:0] a, input bit [1:0] k, input bit u,
                          input bit [7:0] p, input bit [31:0] zp);
    va = a; acc = k; user = u; pid = p; zpr = zp;
  endtask

  // one edge: design captures, model applies the write, then compare
  task automatic cyc(input string tag);
    @(posedge clk);
    if (we) begin
      m_epn[wr_idx] = wr_epn; m_size[wr_idx] = wr_size; m_val[wr_idx] = wr_valid;
      m_rpn[wr_idx] = wr_rpn; m_ex[wr_idx] = wr_ex; m_wr[wr_idx] = wr_wr;
      m_zone[wr_idx] = wr_zone; m_tid[wr_idx] = wr_tid;
    end
    #1;
    check(tag);
    @(negedge clk);
    we = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NE; i++) begin
      set_write(i, 22'h0, 3'd0, 1'b0, 22'h0, 1'b0, 1'b0, 4'd0, 8'd0);
      cyc("R1");
    end
  endtask

  localparam bit [31:0] Z1 = 32'h5555_5555;

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit [31:0] s_pa; bit s_hit;
    void'($urandom(32'd20240917));
    for (int i = 0; i < NE; i++) m_val[i] = 0;
    rst_ni = 0;
    set_write(0, 0, 0, 0, 0, 0, 0, 0, 0); we = 0;
    set_look(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R12");
    rst_ni = 1;
    cyc("R12");

    // R1: write and lookup at the same edge
    set_write(5, 22'h48, 3'd0, 1'b1, 22'h100, 1'b0, 1'b1, 4'd0, 8'd0);
    set_look(32'h0001_2034, 2'd0, 1'b0, 8'd1, Z1);
    cyc("R1");
    set_look(32'h0001_2034, 2'd1, 1'b0, 8'd1, Z1);
    cyc("R8");
    // R8: fetch without execute faults, read fine
    set_look(32'h0001_23FF, 2'd2, 1'b1, 8'd1, Z1);
    cyc("R8");
    set_look(32'h0001_23FF, 2'd3, 1'b1, 8'd1, Z1);
    cyc("R8");

    // R11: mid-cycle input change has no effect
    s_hit = hit_o; s_pa = paddr_o;
    va = 32'hDEAD_BEEF; acc = 2'd1;
    #2;
    n_chk++;
    if (hit_o !== s_hit || paddr_o !== s_pa) begin
      n_bad++;
      $display("FAIL R11: got hit=%0d pa=%h exp hit=%0d pa=%h", hit_o, paddr_o, s_hit, s_pa);
    end

    // R2: invalid entry never matches
    set_write(6, 22'h50, 3'd0, 1'b0, 22'h200, 1'b1, 1'b1, 4'd0, 8'd0);
    set_look(32'h0001_4000, 2'd0, 1'b0, 8'd1, Z1);
    cyc("R2");
    cyc("R2");

    // R3: 16 MB and 4 KB pages
    set_write(10, 22'h4000, 3'd7, 1'b1, 22'h8000, 1'b1, 1'b1, 4'd0, 8'd0);
    set_look(32'h01AB_CDEF, 2'd0, 1'b0, 8'd1, Z1);
    cyc("R3");
    set_look(32'h02AB_CDEF, 2'd0, 1'b0, 8'd1, Z1);
    cyc("R3");
    set_write(11, 22'h0400, 3'd1, 1'b1, 22'h0C01, 1'b1, 1'b1, 4'd0, 8'd0);
    set_look(32'h0010_0FFF, 2'd0, 1'b0, 8'd1, Z1);
    cyc("R3");
    set_look(32'h0010_1000, 2'd0, 1'b0, 8'd1, Z1);
    cyc("R3");

    // R4: owner tag
    set_write(12, 22'h0800, 3'd0, 1'b1, 22'h0123, 1'b1, 1'b1, 4'd0, 8'd7);
    set_look(32'h0020_0010, 2'd0, 1'b0, 8'd7, Z1);
    cyc("R4");
    set_look(32'h0020_0010, 2'd0, 1'b0, 8'd8, Z1);
    cyc("R4");
    set_look(32'h0001_2000, 2'd0, 1'b0, 8'h99, Z1);
    cyc("R4");

    // R5: zone selector above ZONE_MAX acts as code 1
    set_write(13, 22'h0C00, 3'd0, 1'b1, 22'h0321, 1'b0, 1'b0, 4'd13, 8'd0);
    set_look(32'h0030_0004, 2'd0, 1'b1, 8'd1, 32'h0);
    cyc("R5");
    set_look(32'h0030_0004, 2'd1, 1'b1, 8'd1, 32'h0);
    cyc("R5");
    set_write(15, 22'h0D00, 3'd0, 1'b1, 22'h0322, 1'b0, 1'b0, 4'd3, 8'd0);
    set_look(32'h0034_0000, 2'd0, 1'b1, 8'd1, 32'h0);
    cyc("R5");

    // R6: zone code 0 hides from user, search continues
    set_write(2, 22'h1000, 3'd0, 1'b1, 22'h0AAA, 1'b0, 1'b0, 4'd1, 8'd0);
    cyc("R6");
    set_write(9, 22'h1000, 3'd0, 1'b1, 22'h0BBB, 1'b0, 1'b1, 4'd2, 8'd0);
    set_look(32'h0040_0100, 2'd0, 1'b1, 8'd1, zfield(1, 0) | zfield(2, 1));
    cyc("R6");
    set_look(32'h0040_0100, 2'd0, 1'b0, 8'd1, zfield(1, 0) | zfield(2, 1));
    cyc("R6");
    set_look(32'h0040_0100, 2'd1, 1'b1, 8'd1, zfield(1, 0) | zfield(2, 1));
    cyc("R6");

    // R7: code 2 and code 3 overrides
    set_write(14, 22'h1400, 3'd0, 1'b1, 22'h0CCC, 1'b0, 1'b0, 4'd4, 8'd0);
    set_look(32'h0050_0000, 2'd1, 1'b1, 8'd1, zfield(4, 2));
    cyc("R7");
    set_look(32'h0050_0000, 2'd1, 1'b0, 8'd1, zfield(4, 2));
    cyc("R7");
    set_look(32'h0050_0000, 2'd2, 1'b0, 8'd1, zfield(4, 2));
    cyc("R7");
    set_look(32'h0050_0000, 2'd2, 1'b1, 8'd1, zfield(4, 2));
    cyc("R7");
    set_look(32'h0050_0000, 2'd2, 1'b1, 8'd1, zfield(4, 3));
    cyc("R7");
    set_look(32'h0050_0000, 2'd1, 1'b1, 8'd1, zfield(4, 3));
    cyc("R7");

    // R9: lower faulting entry stops the search
    set_write(3, 22'h1800, 3'd0, 1'b1, 22'h0DDD, 1'b0, 1'b0, 4'd0, 8'd0);
    cyc("R9");
    set_write(7, 22'h1800, 3'd0, 1'b1, 22'h0EEE, 1'b1, 1'b1, 4'd0, 8'd0);
    set_look(32'h0060_0000, 2'd1, 1'b0, 8'd1, Z1);
    cyc("R9");
    set_look(32'h0060_0000, 2'd0, 1'b0, 8'd1, Z1);
    cyc("R9");

    // random phase
    clear_all();
    for (int i = 0; i < NE; i++) begin
      int k = int'($urandom % 8);
      set_write(i, 22'((k << 12) | ($urandom & 32'hFFF)), 3'($urandom % 8), 1'($urandom % 8 != 0),
                22'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                8'(($urandom % 2) ? 0 : ($urandom % 4)));
      set_look($urandom, 2'($urandom), 1'($urandom), 8'(1 + $urandom % 3), $urandom);
      cyc("");
    end
    for (int n = 0; n < 3000; n++) begin
      int j = int'($urandom % NE);
      bit [31:0] base = {m_epn[j], 10'b0};
      bit [31:0] a;
      case ($urandom % 4)
        0: a = base | ($urandom & 32'h3FF);
        1: a = base ^ ($urandom & 32'h00FF_FFFF);
        2: a = base ^ ($urandom & 32'h000F_FFFF);
        default: a = $urandom;
      endcase
      if ($urandom % 3 == 0) begin
        int k = int'($urandom % 8);
        int wi = ($urandom % 2) ? j : int'($urandom % NE);
        set_write(wi, 22'((k << 12) | ($urandom & 32'hFFF)), 3'($urandom % 8), 1'($urandom % 8 != 0),
                  22'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                  8'(($urandom % 2) ? 0 : ($urandom % 4)));
      end
      set_look(a, 2'($urandom), 1'($urandom), 8'(1 + $urandom % 3), $urandom);
      cyc("");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule